// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

This block draws into a local pixel memory on behalf of a host. The host sets up a small bank of 32-bit registers: where the source and destination rectangles start, how wide and tall they are, the pixel size, two memory base addresses, a fill colour and the line length. It then writes the control register with its start bit set. The engine supports two operations. Copy moves every pixel of a rectangle from the source position to the destination position. Fill writes one constant colour into every pixel of the destination rectangle.

The engine walks the rectangle row by row and handles one pixel at a time over a request/acknowledge memory port. For a copy it reads the source pixel, waits for the acknowledge, then writes that pixel to the destination. For a fill it only writes. A direction flag makes both walks start at the programmed corner and go backwards, toward lower columns and lower rows, so that a copy between overlapping rectangles can be done safely. Any combination of settings the engine cannot handle is refused: it raises an error flag and finishes without touching memory.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy, done, err and mem_req are 0, and every register reads as 0.
- R2: The registers sit at these byte offsets: 0x00 source position, 0x04 destination position, 0x08 size, 0x0C control, 0x10 mode, 0x14 source base, 0x18 destination base, 0x1C fill colour, 0x20 line total. Each one reads back the value written to it. The exception is control: a read of control returns busy in bit 31, err in bit 30 and the stored bits 29:0. Any other offset in the 0x54-byte window reads 0. A write whose two low address bits are not zero is ignored.
- R3: Opcode 1 (fill) writes the low bytes of the fill colour, one pixel wide, to every pixel of the destination rectangle. It makes no reads and exactly width×height writes.
- R4: Opcode 0 (copy) reads each source pixel and then writes that value to the matching destination pixel. The next read is not issued until the write has been acknowledged. A copy makes width×height reads and width×height writes. An overlapping copy gives the same result as copying the pixels one by one in walk order.
- R5: A pixel's byte address is base[25:0] + (y·stride + x)·bpp. The stride is line-total bits 11:0 plus 1 and is shared by source and destination. Mode bits 21:20 select the pixel size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. mem_size carries this code, and data travels in the low bytes, least significant byte at the lowest address.
- R6: Pixels are visited row by row, with the column changing fastest. When control bit 27 is 0, pixel (row, col) sits at (x0+col, y0+row). When bit 27 is 1, it sits at (x0−col, y0−row).
- R7: Control bits 20:16 hold the opcode. The position registers hold X in bits 28:16 and Y in bits 15:0. The size register holds the width in bits 28:16 and the height in bits 15:0.
- R8: A start with a width or height of zero makes no memory access and never raises busy. done pulses in the cycle after the start.
- R9: A start is refused if mode bits 19:16 are nonzero, the pixel-size code is 3, or the opcode is above 1. A refused start sets err, makes no memory access and pulses done in the next cycle. err stays set until the next accepted start, which clears it.
- R10: busy is 1 from the cycle after an accepted start until the final write has been acknowledged. done then pulses for exactly one cycle.
- R11: While an operation is running, including the cycle in which done is high, every register write is ignored, and that includes a start.
- R12: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until mem_ack arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the pixel |
| mem_size | output | 2 | Pixel-size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| mem_wdata | output | 32 | Pixel to write, in the low bytes |
| mem_rdata | input | 32 | Pixel read, in the low bytes, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was refused |

## Verification
Two events can fall in the same cycle: the completion of an operation and a new register write carrying a start. The bench provokes this by driving a control write with the start bit during the very cycle in which done is high. It then judges the result at the ports: busy must stay low, done must drop, and the write count must not grow. A second collision, between register writes and memory traffic, is provoked by rewriting the fill colour and issuing a start while busy is high. That case is judged by reading the fill register back afterwards and by checking that the memory image holds only the original fill.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned XW       = 13;
    localparam int unsigned YW       = 16;
    localparam int unsigned BASE_W   = 26;
    localparam int unsigned HT_W     = 12;
    localparam int unsigned STRIDE_W = HT_W + 1;
    localparam int unsigned FMT_W    = 2;
    localparam int unsigned OP_W     = 5;
    localparam int unsigned AM_W     = 4;

    // field positions
    localparam int unsigned POS_X_LSB   = 16;
    localparam int unsigned CTRL_OP_LSB = 16;
    localparam int unsigned CTRL_REV    = 27;
    localparam int unsigned CTRL_GO     = 31;
    localparam int unsigned MODE_AM_LSB = 16;
    localparam int unsigned MODE_FMT_LSB = 20;

    localparam logic [OP_W-1:0] OP_COPY = 5'd0;
    localparam logic [OP_W-1:0] OP_FILL = 5'd1;

    // register word indices
    localparam int unsigned RIX_SRC_POS  = 0;
    localparam int unsigned RIX_DST_POS  = 1;
    localparam int unsigned RIX_DIM      = 2;
    localparam int unsigned RIX_CTRL     = 3;
    localparam int unsigned RIX_MODE     = 4;
    localparam int unsigned RIX_SRC_BASE = 5;
    localparam int unsigned RIX_DST_BASE = 6;
    localparam int unsigned RIX_FILL     = 7;
    localparam int unsigned RIX_HTOTAL   = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t src_pos;
        word_t dst_pos;
        word_t dim;
        word_t ctrl;
        word_t mode;
        word_t src_base;
        word_t dst_base;
        word_t fill;
        word_t htotal;
    } regfile_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic                is_copy;
        logic                reverse;
        logic                invalid;
        logic [FMT_W-1:0]    fmt;
        logic [XW-1:0]       width;
        logic [YW-1:0]       height;
        logic [XW-1:0]       src_x;
        logic [YW-1:0]       src_y;
        logic [XW-1:0]       dst_x;
        logic [YW-1:0]       dst_y;
        logic [BASE_W-1:0]   src_base;
        logic [BASE_W-1:0]   dst_base;
        logic [STRIDE_W-1:0] stride;
        word_t               fill;
    } job_t;

    // Build an operation descriptor from the register bank and the control word
    // being written in the launch cycle.
    function automatic job_t decode_job(regfile_t r, word_t ctrl);
        job_t j;
        logic [OP_W-1:0] op;
        op        = ctrl[CTRL_OP_LSB +: OP_W];
        j.is_copy = (op == OP_COPY);
        j.reverse = ctrl[CTRL_REV];
        j.fmt     = r.mode[MODE_FMT_LSB +: FMT_W];
        j.invalid = (r.mode[MODE_AM_LSB +: AM_W] != '0) || (j.fmt == 2'd3) || (op > OP_FILL);
        j.width   = r.dim[POS_X_LSB +: XW];
        j.height  = r.dim[YW-1:0];
        j.src_x   = r.src_pos[POS_X_LSB +: XW];
        j.src_y   = r.src_pos[YW-1:0];
        j.dst_x   = r.dst_pos[POS_X_LSB +: XW];
        j.dst_y   = r.dst_pos[YW-1:0];
        j.src_base = r.src_base[BASE_W-1:0];
        j.dst_base = r.dst_base[BASE_W-1:0];
        j.stride  = {1'b0, r.htotal[HT_W-1:0]} + STRIDE_W'(1);
        j.fill    = r.fill;
        return j;
    endfunction

    // Keep only the bytes that belong to one pixel of the given size code.
    function automatic word_t fit_pixel(word_t v, logic [FMT_W-1:0] fmt);
        word_t res;
        case (fmt)
            2'd0:    res = {24'd0, v[7:0]};
            2'd1:    res = {16'd0, v[15:0]};
            default: res = v;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int unsigned REG_AW        = 7,
    parameter int unsigned REG_WIN_BYTES = 84
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  word_t             wdata,
    input  logic              active,
    input  logic              busy,
    input  logic              err,
    output word_t             rdata,
    output regfile_t          regs,
    output logic              launch
);

    localparam int unsigned WIN_WORDS = REG_WIN_BYTES / 4;
    localparam int unsigned IDX_W     = REG_AW - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             in_win;
    logic             wr_ok;

    always_comb begin
        word_idx = addr[REG_AW-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_win   = (int'(word_idx) < WIN_WORDS);
        wr_ok    = wr && aligned && in_win && !active;
        launch   = wr_ok && (int'(word_idx) == RIX_CTRL) && wdata[CTRL_GO];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_ok) begin
            case (int'(word_idx))
                RIX_SRC_POS:  regs.src_pos  <= wdata;
                RIX_DST_POS:  regs.dst_pos  <= wdata;
                RIX_DIM:      regs.dim      <= wdata;
                RIX_CTRL:     regs.ctrl     <= {2'b00, wdata[29:0]};
                RIX_MODE:     regs.mode     <= wdata;
                RIX_SRC_BASE: regs.src_base <= wdata;
                RIX_DST_BASE: regs.dst_base <= wdata;
                RIX_FILL:     regs.fill     <= wdata;
                RIX_HTOTAL:   regs.htotal   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (int'(word_idx))
                RIX_SRC_POS:  rdata = regs.src_pos;
                RIX_DST_POS:  rdata = regs.dst_pos;
                RIX_DIM:      rdata = regs.dim;
                RIX_CTRL:     rdata = {busy, err, regs.ctrl[29:0]};
                RIX_MODE:     rdata = regs.mode;
                RIX_SRC_BASE: rdata = regs.src_base;
                RIX_DST_BASE: rdata = regs.dst_base;
                RIX_FILL:     rdata = regs.fill;
                RIX_HTOTAL:   rdata = regs.htotal;
                default:      rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [BASE_W-1:0]   base,
    input  logic [XW-1:0]       x0,
    input  logic [YW-1:0]       y0,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [FMT_W-1:0]    fmt,
    input  logic                reverse,
    input  logic                step_col,
    input  logic                step_row,
    output logic [ADDR_W-1:0]   addr
);

    logic [ADDR_W-1:0] start_a;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] pix_q;
    logic [ADDR_W-1:0] row_step_q;
    logic [ADDR_W-1:0] pix_step_q;
    logic              rev_q;
    logic [ADDR_W-1:0] row_nxt;
    logic [ADDR_W-1:0] pix_nxt;

    // One multiply per operation, at load time only.
    always_comb begin
        start_a = ADDR_W'(base)
                + ((ADDR_W'(y0) * ADDR_W'(stride) + ADDR_W'(x0)) << fmt);
        row_nxt = rev_q ? (row_q - row_step_q) : (row_q + row_step_q);
        pix_nxt = rev_q ? (pix_q - pix_step_q) : (pix_q + pix_step_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q      <= '0;
            pix_q      <= '0;
            row_step_q <= '0;
            pix_step_q <= '0;
            rev_q      <= 1'b0;
        end else if (load) begin
            row_q      <= start_a;
            pix_q      <= start_a;
            row_step_q <= ADDR_W'(stride) << fmt;
            pix_step_q <= ADDR_W'(1) << fmt;
            rev_q      <= reverse;
        end else if (step_row) begin
            row_q <= row_nxt;
            pix_q <= row_nxt;
        end else if (step_col) begin
            pix_q <= pix_nxt;
        end
    end

    assign addr = pix_q;

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          invalid,
    input  logic          copy_in,
    input  logic [XW-1:0] width,
    input  logic [YW-1:0] height,
    input  logic          mem_ack,
    output seq_state_e    state,
    output logic          is_copy,
    output logic          load,
    output logic          step_col,
    output logic          step_row,
    output logic          err
);

    seq_state_e    state_q;
    logic [XW-1:0] w_q;
    logic [XW-1:0] col_q;
    logic [YW-1:0] h_q;
    logic [YW-1:0] row_q;
    logic          copy_q;
    logic          err_q;
    logic          last_col;
    logic          last_row;
    logic          wr_done;

    always_comb begin
        last_col = (col_q == w_q - XW'(1));
        last_row = (row_q == h_q - YW'(1));
        wr_done  = (state_q == ST_WRITE) && mem_ack;
        load     = (state_q == ST_IDLE) && launch;
        step_col = wr_done && !last_col;
        step_row = wr_done && last_col && !last_row;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            w_q     <= '0;
            h_q     <= '0;
            col_q   <= '0;
            row_q   <= '0;
            copy_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        w_q    <= width;
                        h_q    <= height;
                        copy_q <= copy_in;
                        col_q  <= '0;
                        row_q  <= '0;
                        err_q  <= invalid;
                        if (invalid || (width == '0) || (height == '0)) begin
                            state_q <= ST_FINISH;
                        end else begin
                            state_q <= copy_in ? ST_READ : ST_WRITE;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        if (last_col) begin
                            col_q <= '0;
                            if (last_row) begin
                                state_q <= ST_FINISH;
                            end else begin
                                row_q   <= row_q + YW'(1);
                                state_q <= copy_q ? ST_READ : ST_WRITE;
                            end
                        end else begin
                            col_q   <= col_q + XW'(1);
                            state_q <= copy_q ? ST_READ : ST_WRITE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign state   = state_q;
    assign is_copy = copy_q;
    assign err     = err_q;

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned REG_WIN_BYTES = 84,
    parameter int unsigned REG_AW        = $clog2(REG_WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int unsigned NUM_CH = 2;   // 0 = source, 1 = destination

    regfile_t          regs;
    job_t              job_now;
    seq_state_e        state;
    logic              launch;
    logic              active;
    logic              seq_load;
    logic              step_col;
    logic              step_row;
    logic              is_copy;
    logic [ADDR_W-1:0] ch_addr [NUM_CH];
    logic [FMT_W-1:0]  fmt_q;
    word_t             fill_q;
    word_t             pix_q;

    assign active  = (state != ST_IDLE);
    assign busy    = (state == ST_READ) || (state == ST_WRITE);
    assign done    = (state == ST_FINISH);
    assign job_now = decode_job(regs, reg_wdata);

    blit_regs #(
        .REG_AW       (REG_AW),
        .REG_WIN_BYTES(REG_WIN_BYTES)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .active(active),
        .busy  (busy),
        .err   (err),
        .rdata (reg_rdata),
        .regs  (regs),
        .launch(launch)
    );

    blit_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .invalid (job_now.invalid),
        .copy_in (job_now.is_copy),
        .width   (job_now.width),
        .height  (job_now.height),
        .mem_ack (mem_ack),
        .state   (state),
        .is_copy (is_copy),
        .load    (seq_load),
        .step_col(step_col),
        .step_row(step_row),
        .err     (err)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_walk
        blit_walker #(
            .ADDR_W(ADDR_W)
        ) walk_i (
            .clk     (clk),
            .rst     (rst),
            .load    (seq_load),
            .base    ((ch == 0) ? job_now.src_base : job_now.dst_base),
            .x0      ((ch == 0) ? job_now.src_x : job_now.dst_x),
            .y0      ((ch == 0) ? job_now.src_y : job_now.dst_y),
            .stride  (job_now.stride),
            .fmt     (job_now.fmt),
            .reverse (job_now.reverse),
            .step_col(step_col),
            .step_row(step_row),
            .addr    (ch_addr[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= '0;
            fill_q <= '0;
            pix_q  <= '0;
        end else begin
            if (seq_load) begin
                fmt_q  <= job_now.fmt;
                fill_q <= job_now.fill;
            end
            if ((state == ST_READ) && mem_ack) begin
                pix_q <= fit_pixel(mem_rdata, fmt_q);
            end
        end
    end

    always_comb begin
        mem_req   = busy;
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_READ) ? ch_addr[0] : ch_addr[1];
        mem_size  = fmt_q;
        mem_wdata = is_copy ? pix_q : fit_pixel(fill_q, fmt_q);
    end

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_FALL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && $past(mem_ack && mem_we))); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_req); // R9

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we)); // R4

endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/blit_engine_tb_top.sv
module blit_engine_tb_top;

    localparam int MEM_BYTES = 4096;
    localparam int A_SRC_POS = 'h00, A_DST_POS = 'h04, A_DIM = 'h08, A_CTRL = 'h0C,
                   A_MODE = 'h10, A_SRC_BASE = 'h14, A_DST_BASE = 'h18, A_FILL = 'h1C,
                   A_HTOTAL = 'h20;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        busy, done, err;

    always #10 clk = ~clk;   // 50 MHz

    blit_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  mem     [MEM_BYTES];
    logic [7:0]  exp_mem [MEM_BYTES];
    logic [31:0] wr_log  [64];
    int rd_cnt = 0, wr_cnt = 0, acc_n = 0, lat = 0;
    bit req_seen = 0;
    logic [31:0] req_a0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // memory model with varying latency, driven just after each rising edge
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack  = 1'b0;
                req_seen = 0;
            end else if (mem_req) begin
                if (!req_seen) begin
                    req_seen = 1;
                    req_a0   = mem_addr;
                    lat      = acc_n % 3;
                    acc_n++;
                end
                if (lat == 0) begin
                    chk_eq("R12 address held until ack", mem_addr, req_a0);
                    mem_rdata = '0;
                    for (int i = 0; i < (1 << mem_size); i++) begin
                        if (mem_we) mem[(mem_addr + i) % MEM_BYTES] = mem_wdata[8*i +: 8];
                        else        mem_rdata[8*i +: 8] = mem[(mem_addr + i) % MEM_BYTES];
                    end
                    if (mem_we) begin
                        if (wr_cnt < 64) wr_log[wr_cnt] = mem_addr;
                        wr_cnt++;
                    end else begin
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                end else begin
                    lat--;
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(a);
        #1;
        d = reg_rdata;
    endtask

    function automatic int unsigned pix_addr(int unsigned base, int x0, int y0, int r, int c,
                                             bit rev, int stride, int bpp);
        int unsigned x, y;
        y = rev ? y0 - r : y0 + r;
        x = rev ? x0 - c : x0 + c;
        return (base & 32'h03FF_FFFF) + (y * stride + x) * bpp;
    endfunction

    // meddle: writes during busy; collide: start write in the done cycle
    task automatic run_op(input int op, input int fmt, input bit rev, input int w, input int h,
                          input logic [31:0] mode_extra, input int dst_b, input bit meddle,
                          input bit collide, input int seed);
        int sx, sy, dx, dy, bpp, stride, t, bytes_bad, n;
        bit bad, expect_busy, ok_order;
        logic [31:0] fill, rb;
        int unsigned sa, da;
        int unsigned src_b;
        src_b  = 32'hFC00_0100;
        stride = 8;
        bpp    = 1 << fmt;
        fill   = 32'hA5C3_9E17 ^ seed;
        sx = rev ? w : 1;      sy = rev ? h : 1;
        dx = sx + 1;           dy = sy + 2;
        bad = (mode_extra[19:16] != 0) || (fmt == 3) || (op > 1);
        expect_busy = !bad && (w != 0) && (h != 0);
        for (int i = 0; i < MEM_BYTES; i++) begin
            mem[i]     = 8'((i * 13 + seed) & 255);
            exp_mem[i] = mem[i];
        end
        if (expect_busy) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    sa = pix_addr(src_b, sx, sy, r, c, rev, stride, bpp);
                    da = pix_addr(dst_b, dx, dy, r, c, rev, stride, bpp);
                    for (int b = 0; b < bpp; b++)
                        exp_mem[(da + b) % MEM_BYTES] = (op == 0) ? exp_mem[(sa + b) % MEM_BYTES]
                                                                  : fill[8*b +: 8];
                end
            end
        end
        wr_reg(A_SRC_POS, (sx << 16) | sy | 32'hE000_0000);
        wr_reg(A_DST_POS, (dx << 16) | dy);
        wr_reg(A_DIM, (w << 16) | h);
        wr_reg(A_MODE, (fmt << 20) | mode_extra);
        wr_reg(A_SRC_BASE, src_b);
        wr_reg(A_DST_BASE, dst_b);
        wr_reg(A_FILL, fill);
        wr_reg(A_HTOTAL, 32'hABC0_F007);   // low 12 bits 7 -> stride 8
        rd_cnt = 0; wr_cnt = 0;
        wr_reg(A_CTRL, 32'h8000_0000 | (32'(rev) << 27) | (op << 16));
        chk_eq(expect_busy ? "R10 busy after start" : "R8 R9 busy stays low", busy, expect_busy);
        if (meddle) begin
            wr_reg(A_FILL, ~fill);
            wr_reg(A_CTRL, 32'h8000_0000);
        end
        t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk_eq("R10 done seen", done, 1'b1);
        chk_eq("R10 busy low with done", busy, 1'b0);
        if (collide) begin
            reg_wr = 1'b1; reg_addr = 7'(A_CTRL); reg_wdata = 32'h8001_0000;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        chk_eq(collide ? "R11 start in done cycle ignored" : "R10 done is one cycle", {busy, done}, 2'b00);
        chk_eq("R9 error flag", err, bad);
        repeat (4) @(negedge clk);
        rd_reg(A_FILL, rb);
        chk_eq("R11 fill register unchanged", rb, fill);
        bytes_bad = 0;
        for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== exp_mem[i]) bytes_bad++;
        chk_eq(op == 0 ? "R4 copy image" : "R3 fill image", bytes_bad, 0);
        n = expect_busy ? w * h : 0;
        chk_eq("R3 R4 write count", wr_cnt, n);
        chk_eq("R3 R4 read count", rd_cnt, (op == 0) ? n : 0);
        ok_order = 1;
        for (int r = 0; r < h && expect_busy; r++)
            for (int c = 0; c < w; c++)
                if (r * w + c < 64 &&
                    wr_log[r * w + c] !== pix_addr(dst_b, dx, dy, r, c, rev, stride, bpp)) ok_order = 0;
        chk_eq("R5 R6 R7 write address order", ok_order, 1'b1);
    endtask

    initial begin
        logic [31:0] rb;
        int seed;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1 outputs after reset", {busy, done, err, mem_req}, 4'b0000);
        for (int a = 0; a <= 'h20; a += 4) begin
            rd_reg(a, rb);
            chk_eq("R1 register after reset", rb, 32'h0);
        end
        // R2: readback, unmapped, misaligned
        for (int a = 0; a <= 'h20; a += 4) begin
            if (a != A_CTRL) begin
                wr_reg(a, 32'h1357_0000 + a * 32'h0101);
                rd_reg(a, rb);
                chk_eq("R2 register readback", rb, 32'h1357_0000 + a * 32'h0101);
            end
        end
        wr_reg(A_CTRL, 32'h0801_0002);
        rd_reg(A_CTRL, rb);
        chk_eq("R2 control readback", rb, 32'h0801_0002);
        wr_reg('h01, 32'hDEAD_BEEF);
        rd_reg(A_SRC_POS, rb);
        chk_eq("R2 misaligned write ignored", rb, 32'h1357_0000);
        wr_reg('h40, 32'hFFFF_FFFF);
        rd_reg('h40, rb);
        chk_eq("R2 unmapped offset reads zero", rb, 32'h0);
        // main sweep
        seed = 1;
        for (int fmt = 0; fmt < 3; fmt++)
            for (int op = 0; op < 2; op++)
                for (int rev = 0; rev < 2; rev++)
                    for (int sh = 0; sh < 3; sh++) begin
                        run_op(op, fmt, rev[0], (sh == 1) ? 3 : (sh == 2) ? 2 : 1,
                               (sh == 1) ? 2 : (sh == 2) ? 3 : 1, 32'h0,
                               (sh == 2) ? 32'h100 : 32'h600, 1'b0, 1'b0, seed);
                        seed += 7;
                    end
        // R8: zero size
        run_op(1, 0, 1'b0, 0, 2, 32'h0, 32'h600, 1'b0, 1'b0, 3);
        run_op(0, 1, 1'b0, 2, 0, 32'h0, 32'h600, 1'b0, 1'b0, 4);
        // R9: refused starts, then recovery
        run_op(1, 0, 1'b0, 2, 2, 32'h0001_0000, 32'h600, 1'b0, 1'b0, 5);
        rd_reg(A_CTRL, rb);
        chk_eq("R9 control bit 30 shows error", rb[30], 1'b1);
        run_op(0, 3, 1'b0, 2, 2, 32'h0, 32'h600, 1'b0, 1'b0, 6);
        run_op(5, 0, 1'b0, 2, 2, 32'h0, 32'h600, 1'b0, 1'b0, 7);
        run_op(1, 2, 1'b1, 2, 2, 32'h0, 32'h600, 1'b0, 1'b0, 8);
        // R11: writes during busy, and start in the done cycle
        run_op(1, 2, 1'b0, 4, 4, 32'h0, 32'h600, 1'b1, 1'b0, 9);
        run_op(0, 1, 1'b1, 3, 3, 32'h0, 32'h100, 1'b0, 1'b1, 10);
        report();
    end

endmodule